// File: doc/BRIEF.md
# I2C Master Bus-Sequence Engine

This block is the bus side of an I2C master. Software asks for one bus primitive at a time by writing a command word with a single bit set: a Start, a Repeated Start, a Stop, an eight-bit receive, or an acknowledge. The matching status bit reads 1 while the block is running that primitive. The block clears it by itself when the primitive is over, so software can poll for completion. The acknowledge polarity is taken from a separate input when the acknowledge command is accepted.

The block never drives a bus line high. It only asserts pull-low enables for the clock and data wires and reads the data wire back while receiving. Every step of a primitive lasts one divider period. That period is set by a 16-bit reload value: a reload of N gives N+1 system clocks per step. A received byte leaves on a valid/ready output. The byte is held, unchanged, until the consumer takes it with `rx_ready`. While a byte is waiting, a new receive command is refused, so no byte is ever overwritten.

Command bit positions in `cmd_set` and `cmd_bits`: bit 0 Start, bit 1 Repeated Start, bit 2 Stop, bit 3 receive, bit 4 acknowledge.

Top module: `i2c_seq_engine`

## Requirements
- R1: After reset, both pull-low enables are 0, `cmd_bits` is 0, `busy` is 0 and `rx_valid` is 0.
- R2: A Start command (bit 0) pulls SDA low in step 1 while SCL stays released. It ends with both lines pulled low, and the status bit clears after 2 steps.
- R3: A Repeated Start command (bit 1) holds SCL low with SDA released in step 0. It releases SCL in step 1 and pulls SDA low in step 2. It ends with both lines low, and the status bit clears after 3 steps.
- R4: A Stop command (bit 2) holds both lines low in step 0 and releases SCL in step 1. It releases SDA in step 2, ends with both lines released, and the status bit clears after 3 steps.
- R5: A receive command (bit 3) makes 8 SCL pulses (low step, then high step). SDA is sampled as SCL rises, MSB first. It ends with SCL low, the status bit clears after 16 steps, and the byte appears on `rx_data` with `rx_valid` = 1.
- R6: An acknowledge command (bit 4) drives SDA low for both of its 2 steps when `ack_nack` was 0 at acceptance, and leaves SDA released when it was 1. SCL is low in step 0 and released in step 1. It ends with SCL low and SDA released.
- R7: A write is accepted only when the block is idle and exactly one command bit is set. Writes while busy and writes with several bits set leave the command state and the bus lines unchanged.
- R8: Each step lasts `half_period`+1 system clocks, so a command of P steps keeps its status bit set for P*(`half_period`+1) cycles.
- R9: `rx_valid` with `rx_data` stays stable until `rx_ready` is high. A receive command written while `rx_valid` is 1 is ignored.
- R10: SDA is never pulled low while a receive is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_set | input | 5 | Command word, one bit per primitive |
| ack_nack | input | 1 | Acknowledge value: 1 sends NACK, 0 sends ACK |
| half_period | input | 16 | Divider reload; step length is this value plus one |
| rx_ready | input | 1 | Consumer takes the received byte |
| sda_in | input | 1 | Level read back from the data wire |
| cmd_bits | output | 5 | Command in progress; a bit clears when its primitive ends |
| busy | output | 1 | Any command in progress |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte waiting for the consumer |
| scl_oe | output | 1 | Pull clock wire low |
| sda_oe | output | 1 | Pull data wire low |

## Verification
On every cycle, the assertions check several rules: at most one status bit is set; a write while busy leaves the command unchanged; SDA is released for the whole receive; and SDA stays steady while SCL is high inside a receive or acknowledge. They also check that the divider counts down by one per cycle, and that a waiting byte and its valid flag hold until they are taken. Only the bench scenarios can show the following: the line pattern of each primitive step by step, the step length for different reload values, the byte value assembled MSB first from a modelled slave, and the ACK or NACK level.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int NCMD = 5;

  // Command indices in the command word; value of the enum is index + 1.
  localparam int B_START  = 0;
  localparam int B_RSTART = 1;
  localparam int B_STOP   = 2;
  localparam int B_RECV   = 3;
  localparam int B_ACK    = 4;

  typedef enum logic [2:0] {
    C_IDLE   = 3'd0,
    C_START  = 3'd1,
    C_RSTART = 3'd2,
    C_STOP   = 3'd3,
    C_RECV   = 3'd4,
    C_ACK    = 3'd5
  } cmd_e;
endpackage

// File: rtl/i2c_seq_divider.sv
module i2c_seq_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = run && !load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load || tick) cnt <= reload;
    else if (run)          cnt <= cnt - 1'b1;
  end

  // R8
  div_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load && (cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/i2c_seq_rxbuf.sv
module i2c_seq_rxbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          bit_in,
  input  logic          byte_done,
  input  logic          take,
  output logic [DW-1:0] data,
  output logic          valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
    end else begin
      if (shift_en) data <= {data[DW-2:0], bit_in};
      if (byte_done)  valid <= 1'b1;
      else if (take)  valid <= 1'b0;
    end
  end

  // R9
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !take |=> valid && $stable(data));
endmodule

// File: rtl/i2c_seq_engine.sv
module i2c_seq_engine
  import i2c_seq_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [NCMD-1:0]   cmd_set,
  input  logic              ack_nack,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              rx_ready,
  input  logic              sda_in,
  output logic [NCMD-1:0]   cmd_bits,
  output logic              busy,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int RX_STEPS = 2 * DATA_W;
  localparam int STEP_W   = $clog2(RX_STEPS);

  cmd_e              cur, req;
  logic [STEP_W-1:0] step;
  logic              sda_q, scl_q, nack_q;
  logic              accept, tick, last;
  logic              shift_en, byte_done;

  // {sda_low, scl_low} for a given step of a command
  function automatic logic [1:0] step_pat(cmd_e c, logic [STEP_W-1:0] s, logic nk);
    case (c)
      C_START:  step_pat = (s == 0) ? 2'b00 : 2'b10;
      C_RSTART: step_pat = (s == 0) ? 2'b01 : ((s == 1) ? 2'b00 : 2'b10);
      C_STOP:   step_pat = (s == 0) ? 2'b11 : ((s == 1) ? 2'b10 : 2'b00);
      C_RECV:   step_pat = s[0] ? 2'b00 : 2'b01;
      C_ACK:    step_pat = {!nk, !s[0]};
      default:  step_pat = 2'b00;
    endcase
  endfunction

  // line state left behind when a command ends
  function automatic logic [1:0] end_pat(cmd_e c);
    case (c)
      C_START, C_RSTART: end_pat = 2'b11;
      C_RECV, C_ACK:     end_pat = 2'b01;
      default:           end_pat = 2'b00;
    endcase
  endfunction

  always_comb begin
    req = C_IDLE;
    if (cmd_set[B_START])  req = C_START;
    if (cmd_set[B_RSTART]) req = C_RSTART;
    if (cmd_set[B_STOP])   req = C_STOP;
    if (cmd_set[B_RECV])   req = C_RECV;
    if (cmd_set[B_ACK])    req = C_ACK;
  end

  assign accept = cmd_wr && (cur == C_IDLE) && $onehot(cmd_set)
                  && !(cmd_set[B_RECV] && rx_valid);

  always_comb begin
    case (cur)
      C_START, C_ACK:  last = (step == STEP_W'(1));
      C_RSTART, C_STOP: last = (step == STEP_W'(2));
      C_RECV:          last = (step == STEP_W'(RX_STEPS - 1));
      default:         last = 1'b0;
    endcase
  end

  i2c_seq_divider #(.W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .run    (cur != C_IDLE),
    .reload (half_period),
    .tick   (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= C_IDLE;
      step   <= '0;
      sda_q  <= 1'b0;
      scl_q  <= 1'b0;
      nack_q <= 1'b0;
    end else if (accept) begin
      cur            <= req;
      step           <= '0;
      nack_q         <= ack_nack;
      {sda_q, scl_q} <= step_pat(req, '0, ack_nack);
    end else if (tick) begin
      if (last) begin
        cur            <= C_IDLE;
        {sda_q, scl_q} <= end_pat(cur);
      end else begin
        step           <= step + 1'b1;
        {sda_q, scl_q} <= step_pat(cur, step + 1'b1, nack_q);
      end
    end
  end

  // SCL rises at the end of each even (low) receive step
  assign shift_en  = tick && (cur == C_RECV) && !step[0];
  assign byte_done = tick && (cur == C_RECV) && last;

  i2c_seq_rxbuf #(.DW(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .bit_in    (sda_in),
    .byte_done (byte_done),
    .take      (rx_ready),
    .data      (rx_data),
    .valid     (rx_valid)
  );

  for (genvar i = 0; i < NCMD; i++) begin : g_status
    assign cmd_bits[i] = (cur == cmd_e'(3'(i + 1)));
  end

  assign busy   = (cur != C_IDLE);
  assign scl_oe = scl_q;
  assign sda_oe = sda_q;

  // R7
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_bits));

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr && !tick |=> cmd_bits == $past(cmd_bits));

  // R10
  rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur == C_RECV |-> !sda_oe);

  // R5
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == C_RECV || cur == C_ACK) && cur == $past(cur) && !scl_q && !$past(scl_q)
    |-> $stable(sda_q));
endmodule

// File: tb/sim_i2c_seq_engine.sv
module sim_i2c_seq_engine;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [4:0]  cmd;
    logic        ackv;
    logic [7:0]  sbyte;
    logic [4:0]  nph;
    logic [15:0] sda_e;
    logic [15:0] scl_e;
    logic        fin_sda;
    logic        fin_scl;
  } vec_t;

  // bit 0 Start, 1 Repeated Start, 2 Stop, 3 receive, 4 acknowledge
  localparam vec_t VEC [9] = '{
    '{5'b00001, 1'b0, 8'h00,  5'd2, 16'h0002, 16'h0000, 1'b1, 1'b1},
    '{5'b01000, 1'b0, 8'hA5, 5'd16, 16'h0000, 16'h5555, 1'b0, 1'b1},
    '{5'b10000, 1'b0, 8'h00,  5'd2, 16'h0003, 16'h0001, 1'b0, 1'b1},
    '{5'b01000, 1'b0, 8'h3C, 5'd16, 16'h0000, 16'h5555, 1'b0, 1'b1},
    '{5'b10000, 1'b1, 8'h00,  5'd2, 16'h0000, 16'h0001, 1'b0, 1'b1},
    '{5'b00010, 1'b0, 8'h00,  5'd3, 16'h0004, 16'h0001, 1'b1, 1'b1},
    '{5'b01000, 1'b0, 8'h81, 5'd16, 16'h0000, 16'h5555, 1'b0, 1'b1},
    '{5'b10000, 1'b1, 8'h00,  5'd2, 16'h0000, 16'h0001, 1'b0, 1'b1},
    '{5'b00100, 1'b0, 8'h00,  5'd3, 16'h0003, 16'h0001, 1'b0, 1'b0}
  };

  logic        clk = 0, rst_n = 0;
  logic        cmd_wr = 0, ack_nack = 0, rx_ready = 0;
  logic [4:0]  cmd_set = 0;
  logic [15:0] half_period = 16'd3;
  logic        sda_in;
  logic [4:0]  cmd_bits;
  logic        busy, rx_valid, scl_oe, sda_oe;
  logic [7:0]  rx_data;
  logic [7:0]  slave_sh = 8'hFF;
  int          errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // slave model: presents next bit after each SCL rise
  always @(negedge scl_oe) slave_sh = {slave_sh[6:0], 1'b1};
  assign sda_in = !sda_oe && slave_sh[7];

  i2c_seq_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_set(cmd_set),
    .ack_nack(ack_nack), .half_period(half_period), .rx_ready(rx_ready),
    .sda_in(sda_in), .cmd_bits(cmd_bits), .busy(busy), .rx_data(rx_data),
    .rx_valid(rx_valid), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [4:0] c, input logic a, output int cyc,
                        output logic [15:0] sp, output logic [15:0] cp);
    @(negedge clk); cmd_wr = 1; cmd_set = c; ack_nack = a;
    @(negedge clk); cmd_wr = 0; cmd_set = 0;
    cyc = 0; sp = 0; cp = 0;
    while (busy && cyc < 2000) begin
      cyc++;
      if ((cyc - 1) % (int'(half_period) + 1) == 0 && (cyc - 1) / (int'(half_period) + 1) < 16) begin
        sp[(cyc - 1) / (int'(half_period) + 1)] = sda_oe;
        cp[(cyc - 1) / (int'(half_period) + 1)] = scl_oe;
      end
      @(negedge clk);
    end
  endtask

  task automatic take_byte();
    rx_ready = 1; @(negedge clk); rx_ready = 0;
  endtask

  function automatic string tag_of(input logic [4:0] c);
    case (c)
      5'b00001: return "R2";
      5'b00010: return "R3";
      5'b00100: return "R4";
      5'b01000: return "R5";
      default:  return "R6";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int          cyc;
    logic [15:0] sp, cp;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 scl_oe", scl_oe, 0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 cmd_bits", cmd_bits, 0);
    check("R1 busy", busy, 0);
    check("R1 rx_valid", rx_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // vector table walk, reload 3
    half_period = 16'd3;
    foreach (VEC[i]) begin
      if (VEC[i].cmd == 5'b01000) slave_sh = VEC[i].sbyte;
      do_cmd(VEC[i].cmd, VEC[i].ackv, cyc, sp, cp);
      check({tag_of(VEC[i].cmd), " R8 duration"}, cyc, VEC[i].nph * 4);
      check({tag_of(VEC[i].cmd), " sda steps"}, sp, VEC[i].sda_e);
      check({tag_of(VEC[i].cmd), " scl steps"}, cp, VEC[i].scl_e);
      check({tag_of(VEC[i].cmd), " end sda"}, sda_oe, VEC[i].fin_sda);
      check({tag_of(VEC[i].cmd), " end scl"}, scl_oe, VEC[i].fin_scl);
      if (VEC[i].cmd == 5'b01000) begin
        check("R10 sda released in receive", sp, 0);
        check("R5 rx_valid", rx_valid, 1);
        check("R5 rx_data", rx_data, VEC[i].sbyte);
        take_byte();
        check("R9 valid cleared by ready", rx_valid, 0);
      end
    end

    // R8 step length follows reload
    half_period = 16'd0;
    do_cmd(5'b00001, 0, cyc, sp, cp);
    check("R8 start reload 0", cyc, 2);
    half_period = 16'd6;
    do_cmd(5'b00100, 0, cyc, sp, cp);
    check("R8 stop reload 6", cyc, 21);

    // R7 write while busy is ignored
    half_period = 16'd3;
    @(negedge clk); cmd_wr = 1; cmd_set = 5'b00001;
    @(negedge clk); cmd_set = 5'b00100;
    @(negedge clk); cmd_wr = 0; cmd_set = 0;
    check("R7 busy write ignored", cmd_bits, 5'b00001);
    while (busy) @(negedge clk);
    check("R7 start end sda", sda_oe, 1);
    check("R7 start end scl", scl_oe, 1);

    // R7 several bits set is ignored
    @(negedge clk); cmd_wr = 1; cmd_set = 5'b01100;
    @(negedge clk); cmd_wr = 0; cmd_set = 0;
    check("R7 multi-bit busy", busy, 0);
    check("R7 multi-bit cmd_bits", cmd_bits, 0);
    check("R7 multi-bit lines", {sda_oe, scl_oe}, 2'b11);

    // R9 back-pressure
    half_period = 16'd1;
    slave_sh = 8'h5A;
    do_cmd(5'b01000, 0, cyc, sp, cp);
    repeat (5) @(negedge clk);
    check("R9 valid held", rx_valid, 1);
    check("R9 data held", rx_data, 8'h5A);
    slave_sh = 8'h00;
    @(negedge clk); cmd_wr = 1; cmd_set = 5'b01000;
    @(negedge clk); cmd_wr = 0; cmd_set = 0;
    check("R9 receive refused while valid", busy, 0);
    check("R9 data unchanged", rx_data, 8'h5A);
    take_byte();
    check("R9 valid cleared", rx_valid, 0);

    do_cmd(5'b00100, 0, cyc, sp, cp);
    check("R4 final stop lines", {sda_oe, scl_oe}, 2'b00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule